// File: doc/BRIEF.md
# Control-Flow Edge Verification Cache

This block remembers indirect control-flow edges that have already been proven legal. Each edge is a pair made of a 64-bit source address and a 64-bit target address. A lookup asks whether an exact pair is on record, and the answer arrives one cycle later. An insert records a newly validated pair. Both addresses are stored at full width, so a forged address can never match an entry by sharing a partial tag with it.

The set index is taken from the XOR of the two addresses. The tag is the complete pair. Each way has a valid bit and a usefulness bit, and a hit sets the usefulness bit. On insertion the block fills empty ways first. When the set is full, it evicts a way whose usefulness bit is clear, chosen pseudo-randomly. When every usefulness bit in the set is set, it clears them all and picks any way.

Top module: `edge_verify_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and `lkRespValid` and `lkHit` are 0.
- R2: The set index is bits [ALIGN+log2(SETS)-1 : ALIGN] of `src ^ tgt` (defaults: 64 sets, 4 ways, ALIGN = 2, so bits [7:2]). Pairs with different indices never evict each other, and at most WAYS pairs with the same index are held at once.
- R3: A lookup hits only when a valid entry holds both the full 64-bit source and the full 64-bit target of the query. A query that differs in any single bit misses, including a pair whose two addresses are swapped or that has the same bit flipped in both addresses.
- R4: `lkRespValid` and `lkHit` are registered. They reflect the lookup presented in the previous cycle and are both 0 in the cycle after a cycle with no lookup. A lookup sees the cache contents from before any insert presented in the same cycle.
- R5: Inserting a pair that is absent writes it into one way with its valid bit set and its usefulness bit clear. Inserting a pair that is already present only sets that entry's usefulness bit, and never creates a second copy.
- R6: A lookup that hits sets the usefulness bit of the entry it hit.
- R7: The candidate ways for a new entry are chosen in this order. First, the invalid ways, if any exist. Otherwise, the valid ways whose usefulness bit is clear. Otherwise, all ways, in which case every usefulness bit in that set is cleared.
- R8: The victim comes from a 16-bit LFSR. It resets to 16'hACE1, advances on every clock after reset as `{q[14:0], q[15]^q[13]^q[12]^q[10]}`, and its value before the edge is used. With r = q[1:0], the victim is the first candidate way found at positions (r+0), (r+1), (r+2), (r+3) mod 4.
- R9: When a lookup and an insert fall in the same set in the same cycle, the lookup's usefulness update is applied first. The insert's clear-all and its write of a zero usefulness bit to the victim then override it. The insert's choice of candidates uses the usefulness bits from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request this cycle |
| lkSrc | input | 64 | Lookup source address |
| lkTgt | input | 64 | Lookup target address |
| insValid | input | 1 | Insert request this cycle |
| insSrc | input | 64 | Insert source address |
| insTgt | input | 64 | Insert target address |
| lkRespValid | output | 1 | Lookup response valid (one cycle after request) |
| lkHit | output | 1 | Lookup hit result |

## Verification
The hardest situation to create is a single set whose ways are all valid while their usefulness bits are in a chosen mix, because only a fixed pattern of inserts and hitting lookups leads there. The stimulus crafts pairs whose XOR lands on a chosen index and fills one set with them. Hitting lookups then mark selected ways, so the eviction of the one unmarked way and the clear-all case can both be forced. One directed step presents a hitting lookup and an insert to the same full set together. A random phase draws from a small pool of colliding pairs, flips single bits in some queries, and checks every response against a bench model of the contents and of the LFSR.

// File: rtl/ec_pkg.sv
package ec_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic lkMark;    // lookup hit: set usefulness of hit way
    logic insMark;   // insert of a present pair: set its usefulness
    logic insWrite;  // insert of an absent pair: write victim way
    logic insClear;  // insert into fully useful set: clear set usefulness
  } ecStrobe_t;

  localparam int LFSR_W = 16;

  function automatic logic [LFSR_W-1:0] lfsrStep(input logic [LFSR_W-1:0] q);
    return {q[LFSR_W-2:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
  endfunction
endpackage

// File: rtl/ec_datapath.sv
module ec_datapath
  import ec_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  parameter int ALIGN  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lkSrc,
  input  logic [ADDR_W-1:0] lkTgt,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] insSrc,
  input  logic [ADDR_W-1:0] insTgt,
  input  ecStrobe_t         st,
  input  logic [WAYS-1:0]   victim,
  output logic [WAYS-1:0]   lkMatch,
  output logic [WAYS-1:0]   insMatch,
  output logic [WAYS-1:0]   insValidVec,
  output logic [WAYS-1:0]   insUsefulVec,
  output logic              lkRespValid,
  output logic              lkHit
);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;

  logic [ADDR_W-1:0] srcMem [SETS][WAYS];
  logic [ADDR_W-1:0] tgtMem [SETS][WAYS];
  logic [WAYS-1:0]   validBits  [SETS];
  logic [WAYS-1:0]   usefulBits [SETS];

  logic [ADDR_W-1:0] lkXor, insXor;
  logic [IDX_W-1:0]  lkIdx, insIdx;
  logic [WAYS-1:0]   insNextUse;

  assign lkXor  = lkSrc ^ lkTgt;
  assign insXor = insSrc ^ insTgt;
  assign lkIdx  = lkXor[ALIGN +: IDX_W];
  assign insIdx = insXor[ALIGN +: IDX_W];

  // Full-width tag compare for both ports
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lkMatch[w]  = validBits[lkIdx][w] &&
                         (srcMem[lkIdx][w] == lkSrc) && (tgtMem[lkIdx][w] == lkTgt);
    assign insMatch[w] = validBits[insIdx][w] &&
                         (srcMem[insIdx][w] == insSrc) && (tgtMem[insIdx][w] == insTgt);
  end

  assign insValidVec  = validBits[insIdx];
  assign insUsefulVec = usefulBits[insIdx];

  // Usefulness of the insert set after this cycle: lookup first, insert last
  always_comb begin
    insNextUse = usefulBits[insIdx];
    if (st.lkMark && (lkIdx == insIdx)) insNextUse = insNextUse | lkMatch;
    if (st.insClear) insNextUse = '0;
    if (st.insMark)  insNextUse = insNextUse | insMatch;
    if (st.insWrite) insNextUse = insNextUse & ~victim;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validBits[s]  <= '0;
        usefulBits[s] <= '0;
      end
      lkRespValid <= 1'b0;
      lkHit       <= 1'b0;
    end else begin
      lkRespValid <= lkValid;
      lkHit       <= st.lkMark;
      if (st.lkMark) usefulBits[lkIdx] <= usefulBits[lkIdx] | lkMatch;
      if (st.insMark || st.insWrite) usefulBits[insIdx] <= insNextUse;
      if (st.insWrite) validBits[insIdx] <= validBits[insIdx] | victim;
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (st.insWrite && victim[w]) begin
        srcMem[insIdx][w] <= insSrc;
        tgtMem[insIdx][w] <= insTgt;
      end
    end
  end

  // No pair is ever held twice in a set
  assert_single_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> $onehot0(lkMatch));

  // A written victim is valid on the next cycle
  assert_written_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.insWrite |=> ((validBits[$past(insIdx)] & $past(victim)) != '0));

  // Response follows request by one cycle
  assert_resp_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> lkRespValid);
  assert_idle_resp_R4: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> (!lkRespValid && !lkHit));
endmodule

// File: rtl/ec_control.sv
module ec_control
  import ec_pkg::*;
#(
  parameter int WAYS = 4,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lkValid,
  input  logic            insValid,
  input  logic [WAYS-1:0] lkMatch,
  input  logic [WAYS-1:0] insMatch,
  input  logic [WAYS-1:0] insValidVec,
  input  logic [WAYS-1:0] insUsefulVec,
  output ecStrobe_t       st,
  output logic [WAYS-1:0] victim
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [LFSR_W-1:0] lfsr;
  logic [WAY_W-1:0]  rot;
  logic [WAYS-1:0]   cand;
  logic              anyInvalid, anyNotUseful;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= LFSR_SEED;
    else       lfsr <= lfsrStep(lfsr);
  end

  assign rot          = lfsr[WAY_W-1:0];
  assign anyInvalid   = ~&insValidVec;
  assign anyNotUseful = ~&insUsefulVec;

  assign st.lkMark   = lkValid && (|lkMatch);
  assign st.insMark  = insValid && (|insMatch);
  assign st.insWrite = insValid && !(|insMatch);
  assign st.insClear = st.insWrite && !anyInvalid && !anyNotUseful;

  always_comb begin
    if (anyInvalid)        cand = ~insValidVec;
    else if (anyNotUseful) cand = ~insUsefulVec;
    else                   cand = '1;
  end

  // First candidate at or after the rotation point
  always_comb begin
    logic [WAY_W-1:0] pos;
    victim = '0;
    for (int k = WAYS - 1; k >= 0; k--) begin
      pos = rot + WAY_W'(k);
      if (cand[pos]) victim = WAYS'(1) << pos;
    end
  end

  assert_victim_one_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.insWrite |-> ($countones(victim) == 1));
  assert_invalid_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.insWrite && anyInvalid) |-> ((victim & insValidVec) == '0));
  assert_keep_useful_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.insWrite && !anyInvalid && anyNotUseful) |-> ((victim & insUsefulVec) == '0));
  assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lfsr != '0) |=> (lfsr != $past(lfsr)));
endmodule

// File: rtl/edge_verify_cache.sv
module edge_verify_cache
  import ec_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  parameter int ALIGN  = 2,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkSrc,
  input  logic [ADDR_W-1:0] lkTgt,
  input  logic              insValid,
  input  logic [ADDR_W-1:0] insSrc,
  input  logic [ADDR_W-1:0] insTgt,
  output logic              lkRespValid,
  output logic              lkHit
);
  ecStrobe_t       st;
  logic [WAYS-1:0] victim, lkMatch, insMatch, insValidVec, insUsefulVec;

  ec_control #(.WAYS(WAYS), .LFSR_SEED(LFSR_SEED)) u_ctl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .insValid(insValid),
    .lkMatch(lkMatch), .insMatch(insMatch), .insValidVec(insValidVec),
    .insUsefulVec(insUsefulVec), .st(st), .victim(victim)
  );

  ec_datapath #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .ALIGN(ALIGN)) u_dp (
    .clk(clk), .rstN(rstN), .lkSrc(lkSrc), .lkTgt(lkTgt), .lkValid(lkValid),
    .insSrc(insSrc), .insTgt(insTgt), .st(st), .victim(victim),
    .lkMatch(lkMatch), .insMatch(insMatch), .insValidVec(insValidVec),
    .insUsefulVec(insUsefulVec), .lkRespValid(lkRespValid), .lkHit(lkHit)
  );
endmodule

// File: tb/tb_edge_verify_cache.sv
`timescale 1ns/1ps
module tb_edge_verify_cache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0, insValid = 1'b0;
  logic [63:0] lkSrc = '0, lkTgt = '0, insSrc = '0, insTgt = '0;
  logic        lkRespValid, lkHit;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  edge_verify_cache dut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkSrc(lkSrc), .lkTgt(lkTgt),
    .insValid(insValid), .insSrc(insSrc), .insTgt(insTgt),
    .lkRespValid(lkRespValid), .lkHit(lkHit)
  );

  // Bench model
  logic [63:0] mSrc [64][4];
  logic [63:0] mTgt [64][4];
  bit   [3:0]  mV [64];
  bit   [3:0]  mU [64];
  logic [15:0] mLfsr;

  function automatic int idxOf(input logic [63:0] s, input logic [63:0] t);
    logic [63:0] x;
    x = s ^ t;
    return int'(x[7:2]);
  endfunction

  function automatic int findWay(input logic [63:0] s, input logic [63:0] t);
    int ix;
    ix = idxOf(s, t);
    for (int w = 0; w < 4; w++)
      if (mV[ix][w] && mSrc[ix][w] == s && mTgt[ix][w] == t) return w;
    return -1;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // One clock: drive at negedge, update model, sample at next negedge
  task automatic step(input bit lv, input logic [63:0] ls, input logic [63:0] lt,
                      input bit iv, input logic [63:0] is_, input logic [63:0] it,
                      input string tag);
    int lset, lw, iset, iw, vic;
    bit expHit, clr;
    bit [3:0] cand, base;
    logic [1:0] r;
    lkValid = lv; lkSrc = ls; lkTgt = lt;
    insValid = iv; insSrc = is_; insTgt = it;
    lset = idxOf(ls, lt);
    lw = findWay(ls, lt);
    expHit = lv && (lw >= 0);
    iset = idxOf(is_, it);
    iw = findWay(is_, it);
    vic = -1; clr = 0; cand = '0;
    if (iv && iw < 0) begin
      if (mV[iset] != 4'hF) cand = ~mV[iset];
      else if (mU[iset] != 4'hF) cand = ~mU[iset];
      else begin cand = 4'hF; clr = 1; end
      r = mLfsr[1:0];
      for (int k = 3; k >= 0; k--) begin
        logic [1:0] p;
        p = r + 2'(k);
        if (cand[p]) vic = int'(p);
      end
    end
    if (expHit) mU[lset][lw] = 1'b1;
    if (iv) begin
      base = mU[iset];
      if (iw >= 0) base[iw] = 1'b1;
      else begin
        if (clr) base = '0;
        base[vic] = 1'b0;
        mV[iset][vic] = 1'b1;
        mSrc[iset][vic] = is_;
        mTgt[iset][vic] = it;
      end
      mU[iset] = base;
    end
    mLfsr = {mLfsr[14:0], mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10]};
    @(posedge clk);
    @(negedge clk);
    check({tag, " R4 lkRespValid"}, int'(lkRespValid), int'(lv));
    check({tag, " lkHit"}, int'(lkHit), int'(expHit));
    lkValid = 0; insValid = 0;
  endtask

  task automatic idle();
    step(0, '0, '0, 0, '0, '0, "idle R4");
  endtask

  task automatic ins(input logic [63:0] s, input logic [63:0] t, input string tag);
    step(0, '0, '0, 1, s, t, tag);
  endtask

  task automatic look(input logic [63:0] s, input logic [63:0] t, input string tag);
    step(1, s, t, 0, '0, '0, tag);
  endtask

  task automatic mkPair(input int set, output logic [63:0] s, output logic [63:0] t);
    logic [63:0] hi;
    s  = {$urandom, $urandom};
    hi = {$urandom, $urandom};
    t  = s ^ ((hi & ~64'hFF) | (64'(set) << 2) | 64'(hi[1:0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] s [8];
    logic [63:0] t [8];
    logic [63:0] ps [16];
    logic [63:0] pt [16];
    int hits;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin mV[i] = '0; mU[i] = '0; end
    mLfsr = 16'hACE1;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset lkRespValid", int'(lkRespValid), 0);
    check("R1 reset lkHit", int'(lkHit), 0);
    rstN = 1'b1;

    mkPair(3, s[0], t[0]);
    look(s[0], t[0], "R1 empty lookup");

    // R3 exact full-width match
    ins(s[0], t[0], "R3 insert");
    look(s[0], t[0], "R3 exact hit");
    look(s[0] ^ 64'h8000_0000_0000_0000, t[0] ^ 64'h8000_0000_0000_0000, "R3 bit63 both");
    look(t[0], s[0], "R3 swapped");
    look(s[0] ^ 64'h1, t[0], "R3 src bit0");
    look(s[0], t[0] ^ 64'h1_0000_0000, "R3 tgt bit32");

    // R2 indexing: 5 pairs in distinct sets all kept, 5 in one set hold 4
    for (int i = 0; i < 5; i++) begin mkPair(10 + i, s[i], t[i]); ins(s[i], t[i], "R2 spread"); end
    for (int i = 0; i < 5; i++) look(s[i], t[i], "R2 spread hit");
    hits = 0;
    for (int i = 0; i < 5; i++) begin mkPair(9, s[i], t[i]); ins(s[i], t[i], "R2 same set"); end
    for (int i = 0; i < 5; i++) begin look(s[i], t[i], "R2 same set"); hits += int'(lkHit); end
    check("R2 ways held", hits, 4);

    // R5 duplicate insert keeps a single copy
    for (int i = 0; i < 4; i++) mkPair(20, s[i], t[i]);
    ins(s[0], t[0], "R5 first");
    ins(s[0], t[0], "R5 dup");
    for (int i = 1; i < 4; i++) ins(s[i], t[i], "R5 fill");
    for (int i = 0; i < 4; i++) look(s[i], t[i], "R5 all present");

    // R6/R7 usefulness protects ways; unmarked one is evicted
    for (int i = 0; i < 6; i++) mkPair(30, s[i], t[i]);
    for (int i = 0; i < 4; i++) ins(s[i], t[i], "R7 fill");
    for (int i = 0; i < 3; i++) look(s[i], t[i], "R6 mark");
    ins(s[4], t[4], "R7 evict unmarked");
    look(s[3], t[3], "R7 unmarked gone");
    for (int i = 0; i < 3; i++) look(s[i], t[i], "R6 marked kept");
    look(s[4], t[4], "R7 new present");
    look(s[4], t[4], "R6 mark new");
    ins(s[5], t[5], "R7 clear all");
    look(s[5], t[5], "R7 after clear");
    for (int i = 0; i < 5; i++) look(s[i], t[i], "R7 survivors");

    // R9 / R4 same-cycle lookup and insert in one set
    for (int i = 0; i < 5; i++) mkPair(40, s[i], t[i]);
    for (int i = 0; i < 4; i++) ins(s[i], t[i], "R9 fill");
    for (int i = 1; i < 4; i++) look(s[i], t[i], "R9 mark");
    step(1, s[0], t[0], 1, s[4], t[4], "R9 concurrent");
    look(s[0], t[0], "R9 victim gone");
    for (int i = 1; i < 5; i++) look(s[i], t[i], "R9 rest");
    mkPair(41, s[6], t[6]);
    step(1, s[6], t[6], 1, s[6], t[6], "R4 lookup before insert");
    look(s[6], t[6], "R4 visible next");
    idle();

    // R8 random phase over colliding pool
    for (int i = 0; i < 16; i++) mkPair((i % 2 == 0) ? 5 : 37, ps[i], pt[i]);
    for (int n = 0; n < 800; n++) begin
      int a, b;
      bit lv, iv;
      logic [63:0] qt;
      a = int'($urandom % 16);
      b = int'($urandom % 16);
      lv = ($urandom % 3) != 0;
      iv = ($urandom % 3) == 0;
      qt = pt[a];
      if (($urandom % 8) == 0) qt = qt ^ (64'h1 << ($urandom % 64));
      step(lv, ps[a], qt, iv, ps[b], pt[b], "R8 random");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule